// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block watches the single memory request stream shared by several hardware contexts and keeps, for each context, one reservation for a load-locked / store-conditional pair. A locked load from a cacheable address records which 16-byte granule the context has reserved. A later conditional store from that context succeeds only while the reservation is still held and covers the store address. It then lets the write go through to memory and returns a result code to the issuing context.

Any write that reaches memory removes every context's reservation on the written granule. That covers plain stores, successful conditional stores and uncacheable conditional stores. A failed conditional store drops only the issuing context's reservation. Each context also keeps a count of consecutive conditional-store failures. Every time that count reaches a whole multiple of a configurable period, the block raises a one-cycle warning that names the context.

All results are registered. They appear one clock after the request is presented, together with the memory write enable for that request.

Top module: `lrsc_monitor`

## Requirements
- R1: A request with `req_locked`=1, `req_store`=0, `req_uncached`=0 records a reservation for context `req_ctx` on the granule `req_addr[ADDR_W-1:4]`. A locked load with `req_uncached`=1 records nothing.
- R2: A cacheable conditional store (`req_locked`=1, `req_store`=1) succeeds when the issuing context holds a reservation whose granule equals the store's, with address bits 3:0 ignored. Success gives `rsp_code`=1 and `mem_wr_en`=1 in the same cycle, one clock after the request.
- R3: A cacheable conditional store that fails gives `rsp_code`=0 and `mem_wr_en`=0. It clears the issuing context's reservation and leaves other contexts' reservations unchanged.
- R4: An uncacheable conditional store ignores the reservation and gives `rsp_code`=2 with `mem_wr_en`=1. It resets that context's failure count and the count's warning phase to zero.
- R5: A plain store (`req_locked`=0, `req_store`=1), a successful conditional store and an uncacheable conditional store each drive `mem_wr_en`=1. Each also clears the reservation of every context whose granule equals the written granule, the issuing context included.
- R6: `fail_count` slice `[c*CNT_W +: CNT_W]` counts context c's consecutive cacheable conditional-store failures. It increments on each failure and returns to zero on a success.
- R7: When a failure brings a context's count to a nonzero multiple of `WARN_PERIOD`, `warn_valid` pulses for one cycle, aligned with that response, and `warn_ctx` gives the context.
- R8: `rsp_valid` is one-hot, with bit c standing for context c. It is high for exactly one cycle per conditional store and stays zero for loads, plain stores and idle cycles. `rsp_code` is 0 whenever no response is valid.
- R9: Reset clears every reservation, every failure count and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ctx | input | $clog2(NUM_CTX) | Issuing context |
| req_addr | input | ADDR_W | Physical address |
| req_locked | input | 1 | Locked access (load-locked or conditional store) |
| req_store | input | 1 | Write access |
| req_uncached | input | 1 | Address is uncacheable |
| rsp_valid | output | NUM_CTX | One-hot result strobe per context |
| rsp_code | output | 2 | 0 fail, 1 success, 2 uncacheable |
| mem_wr_en | output | 1 | Write allowed toward memory |
| fail_count | output | NUM_CTX*CNT_W | Consecutive failure counts, context 0 in the low slice |
| warn_valid | output | 1 | Failure warning pulse |
| warn_ctx | output | $clog2(NUM_CTX) | Context named by the warning |

## Verification
The response strobe, result code, write enable, warning and counter update for a request all come from registers loaded on the edge that follows the request. They are therefore due one cycle after the request. The bench drives each request at a falling edge and samples every output at the next falling edge. This puts each check exactly one register stage after its stimulus, away from the active edge. A reservation's own state is never read directly. It is inferred from the code that a later conditional store to the same context returns.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [1:0] {
        RC_FAIL     = 2'd0,
        RC_OK       = 2'd1,
        RC_UNCACHED = 2'd2
    } rsp_code_e;

endpackage

// File: rtl/lrsc_resv_file.sv
module lrsc_resv_file #(
    parameter int NUM_CTX   = 4,
    parameter int TAG_W     = 44,
    localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TAG_W-1:0]      look_tag,
    input  logic                  set_en,
    input  logic [CTX_W-1:0]      set_ctx,
    input  logic                  drop_en,
    input  logic [CTX_W-1:0]      drop_ctx,
    input  logic                  kill_en,
    output logic [NUM_CTX-1:0]    hit_vec
);

    typedef struct packed {
        logic [NUM_CTX-1:0]            vld;
        logic [NUM_CTX-1:0][TAG_W-1:0] tag;
    } resv_t;

    resv_t st_d, st_q;

    always_comb begin
        for (int i = 0; i < NUM_CTX; i++) begin
            hit_vec[i] = st_q.vld[i] && (st_q.tag[i] == look_tag);
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (set_en && set_ctx == CTX_W'(i)) begin
                st_d.vld[i] = 1'b1;
                st_d.tag[i] = look_tag;
            end
            if (drop_en && drop_ctx == CTX_W'(i)) begin
                st_d.vld[i] = 1'b0;
            end
            // a write's knock-out has the last word over any set
            if (kill_en && hit_vec[i]) begin
                st_d.vld[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_chk
        // R5: a matching write leaves no reservation on its granule
        assert_kill_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (kill_en && hit_vec[g]) |=> !st_q.vld[g]);
        // R3: a failed conditional store drops the issuer's flag
        assert_drop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (drop_en && drop_ctx == CTX_W'(g)) |=> !st_q.vld[g]);
        // R1: a locked load arms the reservation unless a write kills it
        assert_set_arms_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (set_en && set_ctx == CTX_W'(g) && !kill_en) |=> (st_q.vld[g] && st_q.tag[g] == $past(look_tag)));
    end

endmodule

// File: rtl/lrsc_fail_track.sv
module lrsc_fail_track #(
    parameter int NUM_CTX     = 4,
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000,
    localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int PH_W       = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ev_fail,
    input  logic                      ev_clear,
    input  logic [CTX_W-1:0]          ev_ctx,
    output logic [NUM_CTX*CNT_W-1:0]  cnt_flat,
    output logic                      warn_valid,
    output logic [CTX_W-1:0]          warn_ctx
);

    typedef struct packed {
        logic [NUM_CTX-1:0][CNT_W-1:0] cnt;
        logic [NUM_CTX-1:0][PH_W-1:0]  ph;
        logic                          wv;
        logic [CTX_W-1:0]              wc;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.wv = 1'b0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (ev_ctx == CTX_W'(i)) begin
                if (ev_clear) begin
                    st_d.cnt[i] = '0;
                    st_d.ph[i]  = '0;
                end else if (ev_fail) begin
                    st_d.cnt[i] = st_q.cnt[i] + 1'b1;
                    if (st_q.ph[i] == PH_W'(WARN_PERIOD - 1)) begin
                        st_d.ph[i] = '0;
                        st_d.wv    = 1'b1;
                        st_d.wc    = ev_ctx;
                    end else begin
                        st_d.ph[i] = st_q.ph[i] + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_flat   = st_q.cnt;
    assign warn_valid = st_q.wv;
    assign warn_ctx   = st_q.wc;

    // R7: a warning always lands on a nonzero multiple of the period
    assert_warn_multiple_R7: assert property (@(posedge clk) disable iff (!rst_n)
        warn_valid |-> (st_q.cnt[warn_ctx] != '0 &&
                        (st_q.cnt[warn_ctx] % CNT_W'(WARN_PERIOD)) == '0));
    // R6: a success or uncacheable store zeroes the count
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_clear |=> st_q.cnt[$past(ev_ctx)] == '0);
    // R6: a failure advances the count by one
    assert_fail_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fail && !ev_clear) |=> st_q.cnt[$past(ev_ctx)] == $past(st_q.cnt[ev_ctx]) + 1'b1);

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
    parameter int NUM_CTX     = 4,
    parameter int ADDR_W      = 48,
    parameter int GRAN_BITS   = 4,
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000,
    localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int TAG_W      = ADDR_W - GRAN_BITS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [CTX_W-1:0]          req_ctx,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      req_locked,
    input  logic                      req_store,
    input  logic                      req_uncached,
    output logic [NUM_CTX-1:0]        rsp_valid,
    output logic [1:0]                rsp_code,
    output logic                      mem_wr_en,
    output logic [NUM_CTX*CNT_W-1:0]  fail_count,
    output logic                      warn_valid,
    output logic [CTX_W-1:0]          warn_ctx
);
    import lrsc_pkg::*;

    typedef struct packed {
        logic [NUM_CTX-1:0] v;
        rsp_code_e          code;
        logic               wr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [NUM_CTX-1:0]   hit_vec;
    logic [TAG_W-1:0]     req_tag;
    logic [GRAN_BITS-1:0] unused_low;
    logic is_ll, is_sc, is_st, own_hit;
    logic sc_ok, sc_fail, sc_unc, kill_en;

    assign req_tag    = req_addr[ADDR_W-1:GRAN_BITS];
    assign unused_low = req_addr[GRAN_BITS-1:0];

    always_comb begin
        is_ll   = req_valid && req_locked && !req_store && !req_uncached;
        is_sc   = req_valid && req_locked && req_store;
        is_st   = req_valid && !req_locked && req_store;
        own_hit = hit_vec[req_ctx];
        sc_ok   = is_sc && !req_uncached && own_hit;
        sc_fail = is_sc && !req_uncached && !own_hit;
        sc_unc  = is_sc && req_uncached;
        kill_en = is_st || sc_ok || sc_unc;
    end

    always_comb begin
        rsp_d      = '0;
        rsp_d.code = RC_FAIL;
        rsp_d.wr   = kill_en;
        if (is_sc) begin
            rsp_d.v[req_ctx] = 1'b1;
            if (sc_unc)     rsp_d.code = RC_UNCACHED;
            else if (sc_ok) rsp_d.code = RC_OK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    lrsc_resv_file #(
        .NUM_CTX (NUM_CTX),
        .TAG_W   (TAG_W)
    ) u_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_tag (req_tag),
        .set_en   (is_ll),
        .set_ctx  (req_ctx),
        .drop_en  (sc_fail),
        .drop_ctx (req_ctx),
        .kill_en  (kill_en),
        .hit_vec  (hit_vec)
    );

    lrsc_fail_track #(
        .NUM_CTX     (NUM_CTX),
        .CNT_W       (CNT_W),
        .WARN_PERIOD (WARN_PERIOD)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_fail    (sc_fail),
        .ev_clear   (sc_ok || sc_unc),
        .ev_ctx     (req_ctx),
        .cnt_flat   (fail_count),
        .warn_valid (warn_valid),
        .warn_ctx   (warn_ctx)
    );

    assign rsp_valid = rsp_q.v;
    assign rsp_code  = rsp_q.code;
    assign mem_wr_en = rsp_q.wr;

    // R8: at most one context sees a result
    assert_rsp_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));
    // R8: a result only follows a conditional store
    assert_rsp_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(req_locked && req_store)) |=> rsp_valid == '0);
    // R2: success carries the memory write
    assert_ok_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid != '0 && rsp_code == 2'd1) |-> mem_wr_en);
    // R3: failure never writes
    assert_fail_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid != '0 && rsp_code == 2'd0) |-> !mem_wr_en);
    // R4: uncacheable conditional store always writes with code 2
    assert_unc_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_locked && req_store && req_uncached) |=> (rsp_code == 2'd2 && mem_wr_en));

endmodule

// File: tb/tb_lrsc_monitor.sv
module tb_lrsc_monitor;

    localparam int N   = 4;
    localparam int AW  = 48;
    localparam int CW  = 32;
    localparam int WP  = 4;

    localparam logic [2:0] OP_NOP = 3'd0, OP_LL = 3'd1, OP_SC = 3'd2,
                           OP_ST  = 3'd3, OP_SCU = 3'd4, OP_LLU = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  ctx;
        logic [15:0] addr;
        logic [3:0]  ev;
        logic [1:0]  ec;
        logic        ew;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{OP_LL,  2'd0, 16'h1000, 4'b0000, 2'd0, 1'b0},
        '{OP_SC,  2'd0, 16'h100C, 4'b0001, 2'd1, 1'b1},
        '{OP_SC,  2'd0, 16'h1000, 4'b0001, 2'd0, 1'b0},
        '{OP_LL,  2'd1, 16'h2000, 4'b0000, 2'd0, 1'b0},
        '{OP_SC,  2'd1, 16'h2010, 4'b0010, 2'd0, 1'b0},
        '{OP_SC,  2'd1, 16'h2000, 4'b0010, 2'd0, 1'b0},
        '{OP_LL,  2'd2, 16'h3000, 4'b0000, 2'd0, 1'b0},
        '{OP_LL,  2'd3, 16'h3008, 4'b0000, 2'd0, 1'b0},
        '{OP_ST,  2'd0, 16'h3004, 4'b0000, 2'd0, 1'b1},
        '{OP_SC,  2'd2, 16'h3000, 4'b0100, 2'd0, 1'b0},
        '{OP_SC,  2'd3, 16'h3000, 4'b1000, 2'd0, 1'b0},
        '{OP_LL,  2'd2, 16'h4000, 4'b0000, 2'd0, 1'b0},
        '{OP_LL,  2'd3, 16'h5000, 4'b0000, 2'd0, 1'b0},
        '{OP_SC,  2'd3, 16'h5000, 4'b1000, 2'd1, 1'b1},
        '{OP_SC,  2'd2, 16'h4000, 4'b0100, 2'd1, 1'b1},
        '{OP_LL,  2'd1, 16'h6000, 4'b0000, 2'd0, 1'b0},
        '{OP_LL,  2'd2, 16'h6000, 4'b0000, 2'd0, 1'b0},
        '{OP_SC,  2'd1, 16'h6004, 4'b0010, 2'd1, 1'b1},
        '{OP_SC,  2'd2, 16'h6000, 4'b0100, 2'd0, 1'b0},
        '{OP_LL,  2'd0, 16'h7000, 4'b0000, 2'd0, 1'b0},
        '{OP_SC,  2'd1, 16'h7000, 4'b0010, 2'd0, 1'b0},
        '{OP_SC,  2'd0, 16'h7000, 4'b0001, 2'd1, 1'b1},
        '{OP_SCU, 2'd0, 16'h8000, 4'b0001, 2'd2, 1'b1},
        '{OP_LLU, 2'd0, 16'h9000, 4'b0000, 2'd0, 1'b0},
        '{OP_SC,  2'd0, 16'h9000, 4'b0001, 2'd0, 1'b0},
        '{OP_NOP, 2'd0, 16'h0000, 4'b0000, 2'd0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_ctx = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_locked = 1'b0, req_store = 1'b0, req_uncached = 1'b0;
    logic [N-1:0]  rsp_valid;
    logic [1:0]    rsp_code;
    logic          mem_wr_en;
    logic [N*CW-1:0] fail_count;
    logic          warn_valid;
    logic [1:0]    warn_ctx;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    lrsc_monitor #(
        .NUM_CTX (N), .ADDR_W (AW), .GRAN_BITS (4), .CNT_W (CW), .WARN_PERIOD (WP)
    ) dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ctx (req_ctx),
        .req_addr (req_addr), .req_locked (req_locked), .req_store (req_store),
        .req_uncached (req_uncached), .rsp_valid (rsp_valid), .rsp_code (rsp_code),
        .mem_wr_en (mem_wr_en), .fail_count (fail_count), .warn_valid (warn_valid),
        .warn_ctx (warn_ctx)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // drive one request at a falling edge, hold it over one rising edge
    task automatic issue(input logic [2:0] op, input logic [1:0] c, input logic [15:0] a);
        req_valid    = (op != OP_NOP);
        req_ctx      = c;
        req_addr     = {32'h0, a};
        req_locked   = (op == OP_LL || op == OP_LLU || op == OP_SC || op == OP_SCU);
        req_store    = (op == OP_SC || op == OP_SCU || op == OP_ST);
        req_uncached = (op == OP_SCU || op == OP_LLU);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [CW-1:0] cnt_of(input int c);
        return fail_count[c*CW +: CW];
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs after reset
        chk("R9 rsp_valid", 64'(rsp_valid), 64'h0);
        chk("R9 mem_wr_en", 64'(mem_wr_en), 64'h0);
        chk("R9 warn_valid", 64'(warn_valid), 64'h0);
        for (int c = 0; c < N; c++) chk("R9 fail_count", 64'(fail_count[c*CW +: CW]), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table: R1 R2 R3 R5 R8 in result codes and strobes
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].op, VEC[i].ctx, VEC[i].addr);
            chk($sformatf("R8 rsp_valid vec %0d", i), 64'(rsp_valid), 64'(VEC[i].ev));
            chk($sformatf("R2/R3/R4 rsp_code vec %0d", i), 64'(rsp_code), 64'(VEC[i].ec));
            chk($sformatf("R5 mem_wr_en vec %0d", i), 64'(mem_wr_en), 64'(VEC[i].ew));
            chk($sformatf("R7 no warn vec %0d", i), 64'(warn_valid), 64'h0);
        end

        // R6: consecutive failure counts after the table
        chk("R6 count ctx0", 64'(cnt_of(0)), 64'd1);
        chk("R6 count ctx1", 64'(cnt_of(1)), 64'd1);
        chk("R6 count ctx2", 64'(cnt_of(2)), 64'd1);
        chk("R6 count ctx3", 64'(cnt_of(3)), 64'd0);

        // R5: uncacheable conditional store knocks out another context
        issue(OP_LL, 2'd1, 16'hA000);
        issue(OP_SCU, 2'd0, 16'hA008);
        chk("R4 code uncached", 64'(rsp_code), 64'd2);
        issue(OP_SC, 2'd1, 16'hA000);
        chk("R5 uncached write kills ctx1", 64'(rsp_code), 64'd0);

        // R7: warning every WP consecutive failures
        for (int k = 1; k <= 2 * WP; k++) begin
            issue(OP_SC, 2'd3, 16'hF000);
            chk($sformatf("R7 warn at fail %0d", k), 64'(warn_valid), 64'((k % WP) == 0));
            if ((k % WP) == 0) chk("R7 warn_ctx", 64'(warn_ctx), 64'd3);
        end
        chk("R6 count after run", 64'(cnt_of(3)), 64'(2 * WP));
        chk("R6 other ctx untouched", 64'(cnt_of(2)), 64'd1);

        // R4: uncacheable store resets count and phase
        issue(OP_SCU, 2'd3, 16'hF000);
        chk("R4 count reset", 64'(cnt_of(3)), 64'd0);
        for (int k = 1; k <= WP; k++) begin
            issue(OP_SC, 2'd3, 16'hF000);
            chk($sformatf("R4/R7 warn after reset fail %0d", k), 64'(warn_valid), 64'(k == WP));
        end
        chk("R6 count before success", 64'(cnt_of(3)), 64'(WP));
        issue(OP_LL, 2'd3, 16'hE000);
        issue(OP_SC, 2'd3, 16'hE004);
        chk("R6 success code", 64'(rsp_code), 64'd1);
        chk("R6 success clears count", 64'(cnt_of(3)), 64'd0);

        // R9: reset drops a held reservation
        issue(OP_LL, 2'd2, 16'hD000);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 count cleared", 64'(cnt_of(0)), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        issue(OP_SC, 2'd2, 16'hD000);
        chk("R9 reservation cleared", 64'(rsp_code), 64'd0);
        chk("R8 strobe ctx2", 64'(rsp_valid), 64'h4);
        issue(OP_NOP, 2'd0, 16'h0);
        chk("R8 strobe one cycle", 64'(rsp_valid), 64'h0);

        done = 1'b1;
        summary();
    end

endmodule